// File: doc/BRIEF.md
# Program-Memory Table Read Unit

This block fetches lookup-table words from a 1024-word, 14-bit program memory. A table-read command carries a mode flag and a destination data-memory address. The 10-bit ROM address is built from an 8-bit table pointer register and two page bits. The page bits are either the current program counter page or a forced last page.

The unit takes two cycles per read. In the first cycle the synchronous ROM is addressed and `busy` is high. In the second cycle the low byte of the word is written to the data-memory write port. In that same cycle the remaining six bits land in a read-only high-byte register whose top two bits read as zero. The table pointer has its own write port and is read back on `tbl_ptr`.

The ROM is modelled with fixed contents. The word at address a is ((a * 693) XOR 0x1C3A) modulo 2^14.

Top module: `tbr_unit`

## Requirements
- R1: After reset, `busy`, `dm_we`, `hi_byte` and `tbl_ptr` are all zero.
- R2: When `ptr_we` is high at a clock edge, `tbl_ptr` shows `ptr_wdata` from the next cycle on.
- R3: With `last_page` low, the fetched ROM address is {`pc_page`[1:0], `tbl_ptr`[7:0]}, with `pc_page` as bits 9:8.
- R4: With `last_page` high, the fetched ROM address is {2'b11, `tbl_ptr`[7:0]}, whatever `pc_page` holds.
- R5: A `start` accepted while idle raises `busy` for exactly the next cycle. In the cycle after that, `dm_we` is high for one cycle, with `dm_addr` equal to the `dst_addr` given with `start`.
- R6: During the `dm_we` cycle, `dm_wdata` is word bits 7:0. From that cycle on, `hi_byte` is {2'b00, word bits 13:8}. The ROM word at address a is ((a*693) ^ 14'h1C3A) mod 2^14.
- R7: `hi_byte` changes only in a `dm_we` cycle and keeps its value between reads. Every read overwrites it.
- R8: `start` while `busy` is high is ignored: no extra `busy` cycle and no extra `dm_we` pulse.
- R9: The read uses the pointer and page as they were when `start` was accepted. A pointer write on the same edge, or a pointer or page change during `busy`, does not alter the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_we | input | 1 | Table pointer write enable |
| ptr_wdata | input | 8 | Table pointer write value |
| tbl_ptr | output | 8 | Table pointer contents |
| start | input | 1 | Table-read command |
| last_page | input | 1 | 0 = current page, 1 = last page |
| pc_page | input | 2 | Program counter bits 9:8 |
| dst_addr | input | 8 | Destination data-memory address |
| busy | output | 1 | First cycle of a read in progress |
| dm_we | output | 1 | Data-memory write strobe |
| dm_addr | output | 8 | Data-memory write address |
| dm_wdata | output | 8 | Data-memory write data (word low byte) |
| hi_byte | output | 8 | Read-only high-byte register |

## Verification
A wrong page select or a stale pointer capture shows as a `dm_wdata` and `hi_byte` pair that matches a different ROM address. Any such mismatch is visible in the second cycle after `start`. A state-machine fault that ignores `busy` shows as a second `dm_we` pulse, or as a busy pulse longer than one cycle, within three cycles. A fault in the high-byte latch shows as `hi_byte` drifting between reads or holding nonzero top bits. The bench samples after every transaction and again one cycle later to catch such faults.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    typedef enum logic {
        PAGE_CURRENT = 1'b0,
        PAGE_LAST    = 1'b1
    } page_mode_e;

    // fixed program image used by the memory model
    function automatic logic [13:0] rom_image(input int unsigned a);
        int unsigned v;
        v = (a * 693) ^ 32'h1C3A;
        return v[13:0];
    endfunction

endpackage

// File: rtl/tbr_addr_gen.sv
module tbr_addr_gen
    import tbr_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int PAGE_W = 2,
    localparam int ADDR_W = PTR_W + PAGE_W
) (
    input  page_mode_e          mode,
    input  logic [PAGE_W-1:0]   pc_page,
    input  logic [PTR_W-1:0]    ptr,
    output logic [ADDR_W-1:0]   rom_addr
);

    logic [PAGE_W-1:0] page_sel;

    always_comb begin
        if (mode == PAGE_LAST) begin
            page_sel = {PAGE_W{1'b1}};
        end else begin
            page_sel = pc_page;
        end
        rom_addr = {page_sel, ptr};
    end

endmodule

// File: rtl/tbr_rom.sv
module tbr_rom
    import tbr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 14,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = WORD_W'(rom_image(i));
        end
    end

    always_ff @(posedge clk) begin
        rdata <= mem[addr];
    end

endmodule

// File: rtl/tbr_unit.sv
module tbr_unit
    import tbr_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int PAGE_W = 2,
    parameter int WORD_W = 14,
    parameter int DATA_W = 8,
    parameter int DST_W  = 8,
    localparam int ADDR_W = PTR_W + PAGE_W,
    localparam int UPPER_W = WORD_W - DATA_W,
    localparam int PAD_W = DATA_W - UPPER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic [PTR_W-1:0]  ptr_wdata,
    output logic [PTR_W-1:0]  tbl_ptr,
    input  logic              start,
    input  logic              last_page,
    input  logic [PAGE_W-1:0] pc_page,
    input  logic [DST_W-1:0]  dst_addr,
    output logic              busy,
    output logic              dm_we,
    output logic [DST_W-1:0]  dm_addr,
    output logic [DATA_W-1:0] dm_wdata,
    output logic [DATA_W-1:0] hi_byte
);

    typedef struct packed {
        logic              busy;
        logic [DST_W-1:0]  dst;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] hi;
        logic [PTR_W-1:0]  ptr;
    } state_t;

    state_t            st_d, st_q;
    logic [ADDR_W-1:0] addr_d;
    logic [WORD_W-1:0] word_q;
    logic              accept_d;
    page_mode_e        mode_d;

    assign mode_d = last_page ? PAGE_LAST : PAGE_CURRENT;

    tbr_addr_gen #(
        .PTR_W  (PTR_W),
        .PAGE_W (PAGE_W)
    ) u_addr (
        .mode     (mode_d),
        .pc_page  (pc_page),
        .ptr      (st_q.ptr),
        .rom_addr (addr_d)
    );

    tbr_rom #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_rom (
        .clk   (clk),
        .addr  (addr_d),
        .rdata (word_q)
    );

    always_comb begin
        st_d     = st_q;
        accept_d = start && !st_q.busy;
        st_d.we  = 1'b0;

        if (ptr_we) begin
            st_d.ptr = ptr_wdata;
        end

        if (accept_d) begin
            st_d.busy = 1'b1;
            st_d.dst  = dst_addr;
        end else begin
            st_d.busy = 1'b0;
        end

        // second cycle: ROM data from the first-cycle address is ready
        if (st_q.busy) begin
            st_d.we    = 1'b1;
            st_d.wdata = word_q[DATA_W-1:0];
            st_d.hi    = {{PAD_W{1'b0}}, word_q[WORD_W-1:DATA_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl_ptr  = st_q.ptr;
    assign busy     = st_q.busy;
    assign dm_we    = st_q.we;
    assign dm_addr  = st_q.dst;
    assign dm_wdata = st_q.wdata;
    assign hi_byte  = st_q.hi;

endmodule

// File: rtl/tbr_unit_chk.sv
module tbr_unit_chk #(
    parameter int PTR_W  = 8,
    parameter int DST_W  = 8,
    parameter int DATA_W = 8,
    parameter int UPPER_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_we,
    input logic [PTR_W-1:0]  ptr_wdata,
    input logic [PTR_W-1:0]  tbl_ptr,
    input logic              start,
    input logic [DST_W-1:0]  dst_addr,
    input logic              busy,
    input logic              dm_we,
    input logic [DST_W-1:0]  dm_addr,
    input logic [DATA_W-1:0] hi_byte
);

    a_r1_reset_idle: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !dm_we && hi_byte == '0 && tbl_ptr == '0));

    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> tbl_ptr == $past(ptr_wdata));

    a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r5_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && dm_we));

    a_r5_we_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> $past(busy));

    a_r5_dst_kept: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> dm_addr == $past(dst_addr, 2));

    a_r7_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dm_we |-> $stable(hi_byte));

    a_r8_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |=> !dm_we);

    always_comb begin
        if (rst_n) begin
            a_r6_hi_pad: assert (hi_byte[DATA_W-1:UPPER_W] == '0);
        end
    end

endmodule

bind tbr_unit tbr_unit_chk #(
    .PTR_W   (PTR_W),
    .DST_W   (DST_W),
    .DATA_W  (DATA_W),
    .UPPER_W (UPPER_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_we    (ptr_we),
    .ptr_wdata (ptr_wdata),
    .tbl_ptr   (tbl_ptr),
    .start     (start),
    .dst_addr  (dst_addr),
    .busy      (busy),
    .dm_we     (dm_we),
    .dm_addr   (dm_addr),
    .hi_byte   (hi_byte)
);

// File: tb/tbr_unit_tb.sv
module tbr_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ptr_we = 1'b0;
    logic [7:0] ptr_wdata = '0;
    logic [7:0] tbl_ptr;
    logic       start = 1'b0;
    logic       last_page = 1'b0;
    logic [1:0] pc_page = '0;
    logic [7:0] dst_addr = '0;
    logic       busy, dm_we;
    logic [7:0] dm_addr, dm_wdata, hi_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .tbl_ptr(tbl_ptr), .start(start), .last_page(last_page),
        .pc_page(pc_page), .dst_addr(dst_addr), .busy(busy), .dm_we(dm_we),
        .dm_addr(dm_addr), .dm_wdata(dm_wdata), .hi_byte(hi_byte)
    );

    function automatic logic [13:0] word_at(input int unsigned a);
        int unsigned m;
        m = ((a * 693) ^ 32'h1C3A) % 16384;
        return m[13:0];
    endfunction

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ptr(input logic [7:0] v);
        ptr_we = 1'b1; ptr_wdata = v;
        step();
        ptr_we = 1'b0;
    endtask

    // issue a read on the next edge, then check both cycles
    task automatic do_read(input string req, input logic lp, input logic [1:0] pg,
                           input logic [7:0] dst, input int unsigned exp_addr);
        logic [13:0] w;
        w = word_at(exp_addr);
        start = 1'b1; last_page = lp; pc_page = pg; dst_addr = dst;
        step();
        start = 1'b0;
        check({req, " R5 busy first cycle"}, busy, 1);
        check({req, " R5 no write first cycle"}, dm_we, 0);
        step();
        check({req, " R5 busy drops"}, busy, 0);
        check({req, " R5 write strobe"}, dm_we, 1);
        check({req, " R5 dst addr"}, dm_addr, dst);
        check({req, " R6 low byte"}, dm_wdata, w[7:0]);
        check({req, " R6 high byte"}, hi_byte, {2'b00, w[13:8]});
        step();
        check({req, " R5 strobe one cycle"}, dm_we, 0);
        check({req, " R7 high byte held"}, hi_byte, {2'b00, w[13:8]});
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 dm_we", dm_we, 0);
        check("R1 hi_byte", hi_byte, 0);
        check("R1 tbl_ptr", tbl_ptr, 0);
    endtask

    task automatic t_ptr_write();
        set_ptr(8'hA5);
        check("R2 pointer load", tbl_ptr, 8'hA5);
        set_ptr(8'h00);
        check("R2 pointer load zero", tbl_ptr, 8'h00);
    endtask

    task automatic t_current_page();
        set_ptr(8'h3C);
        do_read("R3 page0", 1'b0, 2'd0, 8'h11, 10'h03C);
        do_read("R3 page1", 1'b0, 2'd1, 8'h22, 10'h13C);
        set_ptr(8'hFF);
        do_read("R3 page2 top", 1'b0, 2'd2, 8'h33, 10'h2FF);
        do_read("R3 page3", 1'b0, 2'd3, 8'h44, 10'h3FF);
    endtask

    task automatic t_last_page();
        set_ptr(8'h07);
        do_read("R4 last from page0", 1'b1, 2'd0, 8'h55, 10'h307);
        do_read("R4 last from page1", 1'b1, 2'd1, 8'h66, 10'h307);
        set_ptr(8'h00);
        do_read("R4 last low edge", 1'b1, 2'd2, 8'h77, 10'h300);
    endtask

    task automatic t_busy_ignore();
        logic [13:0] w;
        set_ptr(8'h42);
        w = word_at(10'h142);
        start = 1'b1; last_page = 1'b0; pc_page = 2'd1; dst_addr = 8'h90;
        step();
        // start still high and with other fields during busy
        dst_addr = 8'hEE; pc_page = 2'd3;
        check("R8 busy", busy, 1);
        step();
        start = 1'b0;
        check("R8 write", dm_we, 1);
        check("R8 dst of first", dm_addr, 8'h90);
        check("R9 page frozen", dm_wdata, w[7:0]);
        check("R8 busy not rearmed", busy, 0);
        step();
        check("R8 no second strobe", dm_we, 0);
        check("R8 no busy", busy, 0);
    endtask

    task automatic t_ptr_sampled();
        logic [13:0] w;
        set_ptr(8'h10);
        w = word_at(10'h010);
        // pointer write on the same edge as start
        start = 1'b1; last_page = 1'b0; pc_page = 2'd0; dst_addr = 8'h01;
        ptr_we = 1'b1; ptr_wdata = 8'h20;
        step();
        start = 1'b0; ptr_wdata = 8'h30;
        check("R9 new pointer visible", tbl_ptr, 8'h20);
        step();
        ptr_we = 1'b0;
        check("R9 low byte old pointer", dm_wdata, w[7:0]);
        check("R9 high byte old pointer", hi_byte, {2'b00, w[13:8]});
        check("R2 pointer written during busy", tbl_ptr, 8'h30);
        step();
    endtask

    task automatic t_overwrite();
        logic [13:0] w;
        set_ptr(8'h81);
        do_read("R7 first", 1'b1, 2'd0, 8'h02, 10'h381);
        repeat (3) step();
        w = word_at(10'h381);
        check("R7 idle hold", hi_byte, {2'b00, w[13:8]});
        set_ptr(8'h82);
        check("R7 pointer write keeps hi", hi_byte, {2'b00, w[13:8]});
        do_read("R7 second", 1'b0, 2'd0, 8'h03, 10'h082);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_ptr_write();
        t_current_page();
        t_last_page();
        t_busy_ignore();
        t_ptr_sampled();
        t_overwrite();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule